// File: doc/BRIEF.md
# Sliding-Window Cell Histogram Block Buffer

This block sits between a cell histogram generator and the block-level stages of a gradient-histogram person detector. It keeps the 9-bin histograms of every cell in one detection window, a grid 8 cells wide and 16 cells tall (128 cells), in a ring of storage. From those cells it assembles each 2x2 group of neighbouring cells into a 36-value block and streams the blocks out, one every 8 cycles, to the classifier and normaliser downstream.

Cells arrive one per write in raster order. A block is launched as soon as the cells it covers are present, so output starts early in the second cell row rather than after the whole window is filled. When the window steps down by one cell row, only the oldest row of storage is released. The writer then supplies just the 8 new cells of the incoming bottom row, and every block of the new window is streamed again from the retained cells plus that new row. A writer that runs ahead of the block reader is held off through a ready signal.

Top module: `hog_cell_block_buffer`

## Requirements
- R1: After reset, `blk_valid` is 0, `wr_ready` is 1 and no block is emitted until cells are written.
- R2: A cell is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1; bin b of the cell is carried on `wr_bins[b*12 +: 12]`. Accepted cells fill the window in raster order, 8 per row, top row first.
- R3: The block at block row r, block column c is emitted only once cell (r+1, c+1) of the current window has been accepted; in a fresh buffer the first block follows the 10th accepted cell and none is emitted after only 9.
- R4: Blocks of a window are emitted in raster order, block row 0..14 and block column 0..6 (105 per window), with `blk_row` and `blk_col` giving the position while `blk_valid` is 1.
- R5: `blk_bins` holds 36 bins of 12 bits; bin b of the k-th cell is at `blk_bins[(k*9+b)*12 +: 12]`, where k = 0, 1, 2, 3 are cells (r,c), (r,c+1), (r+1,c), (r+1,c+1).
- R6: `blk_valid` is a one-cycle pulse and two pulses are never less than 8 cycles apart; when the next block's cells are already present, the gap is exactly 8 cycles.
- R7: While all 128 cells of the current window are held, `wr_ready` is 0 and a pending write is neither accepted nor has any effect on emitted blocks.
- R8: A window advance, taken only after the window's last block has been emitted, releases the oldest cell row; the new window re-emits all 105 blocks, block rows 0..13 from retained cells at once, and `wr_ready` returns to 1 for exactly 8 new cells.
- R9: A `win_adv` pulse that arrives while the current window is still emitting is remembered and applied as soon as the window's last block has been emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A cell histogram is offered on `wr_bins` |
| wr_bins | input | 108 | Nine 12-bit bins of the offered cell, bin 0 in the low bits |
| wr_ready | output | 1 | The buffer can accept a cell this cycle |
| win_adv | input | 1 | One-cycle request to step the window down one cell row |
| blk_valid | output | 1 | One-cycle pulse: a block is presented |
| blk_row | output | 4 | Block row of the presented block, 0..14 |
| blk_col | output | 3 | Block column of the presented block, 0..6 |
| blk_bins | output | 432 | The 36 bins of the presented block |

## Verification
A wrong ring pointer or a wrong fill count shows at the ports within one block interval: the next emitted block carries bins from a neighbouring or stale cell, or arrives before its bottom-right cell was written, or `wr_ready` sits at the wrong level. A sequencer that loses its place shows as a wrong `blk_row`/`blk_col` on the next pulse or as an emission count that differs from the cell-driven expectation. The advance path is exposed after each window step, where retained rows must reappear with the same contents under new block rows and exactly 8 writes must be admitted.

// File: rtl/hog_cbuf_pkg.sv
package hog_cbuf_pkg;

    // Window geometry in cells and per-cell histogram shape
    localparam int CELLS_X    = 8;
    localparam int CELLS_Y    = 16;
    localparam int BINS       = 9;
    localparam int BIN_W      = 12;
    localparam int BLK_CYCLES = 8;

    // Derived sizes
    localparam int N_CELLS   = CELLS_X * CELLS_Y;
    localparam int CELL_W    = BINS * BIN_W;
    localparam int BLK_X     = CELLS_X - 1;
    localparam int BLK_Y     = CELLS_Y - 1;
    localparam int BLK_CELLS = 4;
    localparam int BLK_W     = BLK_CELLS * CELL_W;
    localparam int ADDR_W    = $clog2(N_CELLS);
    localparam int FILL_W    = $clog2(N_CELLS + 1);
    localparam int ROW_W     = $clog2(CELLS_Y);
    localparam int BROW_W    = $clog2(BLK_Y);
    localparam int BCOL_W    = $clog2(BLK_X);
    localparam int PH_W      = $clog2(BLK_CYCLES);

    typedef enum logic [1:0] {
        SEQ_WAIT,
        SEQ_RUN,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic [BROW_W-1:0] row;
        logic [BCOL_W-1:0] col;
    } blk_pos_t;

    // Physical slot of a cell given the ring row holding window row 0
    function automatic int slot_index(int base_row, int cell_row, int cell_col);
        return ((base_row + cell_row) % CELLS_Y) * CELLS_X + cell_col;
    endfunction

    // Number of window cells that must be present before a block can be read
    function automatic int cells_needed(blk_pos_t p);
        return (int'(p.row) + 1) * CELLS_X + int'(p.col) + 2;
    endfunction

    function automatic logic is_last_block(blk_pos_t p);
        return (int'(p.row) == BLK_Y - 1) && (int'(p.col) == BLK_X - 1);
    endfunction

    function automatic blk_pos_t step_pos(blk_pos_t p);
        blk_pos_t n;
        if (int'(p.col) == BLK_X - 1) begin
            n.col = '0;
            n.row = p.row + 1'b1;
        end else begin
            n.col = p.col + 1'b1;
            n.row = p.row;
        end
        return n;
    endfunction

endpackage

// File: rtl/cbuf_cell_store.sv
module cbuf_cell_store
    import hog_cbuf_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_slot,
    input  logic [CELL_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_slot,
    output logic [CELL_W-1:0] rd_data
);

    logic [CELL_W-1:0] cells [N_CELLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_slot] <= wr_data;
        end
    end

    assign rd_data = cells[rd_slot];

endmodule

// File: rtl/cbuf_fill_tracker.sv
module cbuf_fill_tracker
    import hog_cbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic              adv_apply,
    output logic [FILL_W-1:0] fill,
    output logic [ROW_W-1:0]  base_row,
    output logic [ADDR_W-1:0] wr_slot,
    output logic              wr_ready
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill     <= '0;
            base_row <= '0;
        end else if (adv_apply) begin
            // Oldest ring row leaves the window
            fill <= fill - FILL_W'(CELLS_X);
            if (int'(base_row) == CELLS_Y - 1) begin
                base_row <= '0;
            end else begin
                base_row <= base_row + 1'b1;
            end
        end else if (wr_fire) begin
            fill <= fill + 1'b1;
        end
    end

    assign wr_ready = (int'(fill) < N_CELLS);
    assign wr_slot  = ADDR_W'(slot_index(int'(base_row),
                                         int'(fill) / CELLS_X,
                                         int'(fill) % CELLS_X));

endmodule

// File: rtl/cbuf_block_sequencer.sv
module cbuf_block_sequencer
    import hog_cbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FILL_W-1:0] fill,
    input  logic [ROW_W-1:0]  base_row,
    input  logic              win_adv,
    output logic [ADDR_W-1:0] rd_slot,
    input  logic [CELL_W-1:0] rd_data,
    output logic              adv_apply,
    output logic              blk_valid,
    output blk_pos_t          blk_pos,
    output logic [BLK_W-1:0]  blk_bins
);

    seq_state_e        state;
    logic [PH_W-1:0]   ph;
    blk_pos_t          pos;
    blk_pos_t          nxt_pos;
    logic              adv_pend;
    logic              avail_cur;
    logic              avail_nxt;
    logic [1:0]        cur_k;
    logic [CELL_W-1:0] gathered [BLK_CELLS];
    logic [BLK_W-1:0]  assembled;

    assign nxt_pos   = step_pos(pos);
    assign avail_cur = int'(fill) >= cells_needed(pos);
    assign avail_nxt = int'(fill) >= cells_needed(nxt_pos);
    assign adv_apply = (state == SEQ_DONE) && (adv_pend || win_adv);

    // Phase k (0..3) of a block fetches cell k: bit 1 picks the lower row, bit 0 the right column
    assign cur_k   = ph[1:0];
    assign rd_slot = ADDR_W'(slot_index(int'(base_row),
                                        int'(pos.row) + int'(cur_k[1]),
                                        int'(pos.col) + int'(cur_k[0])));

    generate
        for (genvar k = 0; k < BLK_CELLS; k++) begin : g_gather
            always_ff @(posedge clk) begin
                if (state == SEQ_RUN && int'(ph) == k) begin
                    gathered[k] <= rd_data;
                end
            end
            assign assembled[k*CELL_W +: CELL_W] = gathered[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_WAIT;
            ph        <= '0;
            pos       <= '0;
            adv_pend  <= 1'b0;
            blk_valid <= 1'b0;
            blk_pos   <= '0;
            blk_bins  <= '0;
        end else begin
            blk_valid <= 1'b0;

            if (adv_apply) begin
                adv_pend <= 1'b0;
            end else if (win_adv) begin
                adv_pend <= 1'b1;
            end

            case (state)
                SEQ_WAIT: begin
                    if (avail_cur) begin
                        state <= SEQ_RUN;
                        ph    <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (int'(ph) == BLK_CYCLES - 1) begin
                        blk_valid <= 1'b1;
                        blk_pos   <= pos;
                        blk_bins  <= assembled;
                        ph        <= '0;
                        if (is_last_block(pos)) begin
                            state <= SEQ_DONE;
                        end else begin
                            pos <= nxt_pos;
                            if (!avail_nxt) begin
                                state <= SEQ_WAIT;
                            end
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                SEQ_DONE: begin
                    if (adv_apply) begin
                        pos   <= '0;
                        state <= SEQ_WAIT;
                    end
                end
                default: state <= SEQ_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/hog_cell_block_buffer.sv
module hog_cell_block_buffer
    import hog_cbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [CELL_W-1:0] wr_bins,
    output logic              wr_ready,
    input  logic              win_adv,
    output logic              blk_valid,
    output logic [BROW_W-1:0] blk_row,
    output logic [BCOL_W-1:0] blk_col,
    output logic [BLK_W-1:0]  blk_bins
);

    logic [FILL_W-1:0] fill;
    logic [ROW_W-1:0]  base_row;
    logic [ADDR_W-1:0] wr_slot;
    logic [ADDR_W-1:0] rd_slot;
    logic [CELL_W-1:0] rd_data;
    logic              wr_fire;
    logic              adv_apply;
    blk_pos_t          blk_pos;

    assign wr_fire = wr_valid && wr_ready;

    cbuf_fill_tracker u_fill (
        .clk       (clk),
        .rst       (rst),
        .wr_fire   (wr_fire),
        .adv_apply (adv_apply),
        .fill      (fill),
        .base_row  (base_row),
        .wr_slot   (wr_slot),
        .wr_ready  (wr_ready)
    );

    cbuf_cell_store u_store (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_slot (wr_slot),
        .wr_data (wr_bins),
        .rd_slot (rd_slot),
        .rd_data (rd_data)
    );

    cbuf_block_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .fill      (fill),
        .base_row  (base_row),
        .win_adv   (win_adv),
        .rd_slot   (rd_slot),
        .rd_data   (rd_data),
        .adv_apply (adv_apply),
        .blk_valid (blk_valid),
        .blk_pos   (blk_pos),
        .blk_bins  (blk_bins)
    );

    assign blk_row = blk_pos.row;
    assign blk_col = blk_pos.col;

endmodule

// File: rtl/hog_cell_block_buffer_chk.sv
module hog_cell_block_buffer_chk
    import hog_cbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              blk_valid,
    input logic [BROW_W-1:0] blk_row,
    input logic [BCOL_W-1:0] blk_col,
    input logic              adv_apply
);

    // Shadow occupancy built from port handshakes and applied advances
    logic [FILL_W:0] occ;
    logic [3:0]      since_blk;
    logic            seen_blk;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ       <= '0;
            since_blk <= '0;
            seen_blk  <= 1'b0;
        end else begin
            if (wr_valid && wr_ready) begin
                occ <= occ + 1'b1;
            end else if (adv_apply) begin
                occ <= occ - (FILL_W+1)'(CELLS_X);
            end
            if (blk_valid) begin
                since_blk <= 4'd1;
                seen_blk  <= 1'b1;
            end else if (since_blk != 4'hF) begin
                since_blk <= since_blk + 1'b1;
            end
        end
    end

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready == (int'(occ) < N_CELLS));

    // R3
    cells_present_chk: assert property (@(posedge clk) disable iff (rst)
        blk_valid |-> int'(occ) >= (int'(blk_row) + 1) * CELLS_X + int'(blk_col) + 2);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blk_valid |=> !blk_valid);

    // R6
    block_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && seen_blk) |-> int'(since_blk) >= BLK_CYCLES);

    // R4
    block_range_chk: assert property (@(posedge clk) disable iff (rst)
        blk_valid |-> (int'(blk_row) < BLK_Y) && (int'(blk_col) < BLK_X));

    // R8
    advance_full_chk: assert property (@(posedge clk) disable iff (rst)
        adv_apply |-> int'(occ) == N_CELLS);

endmodule

bind hog_cell_block_buffer hog_cell_block_buffer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .blk_valid (blk_valid),
    .blk_row   (blk_row),
    .blk_col   (blk_col),
    .adv_apply (adv_apply)
);

// File: tb/hog_cell_block_buffer_tb_top.sv
module hog_cell_block_buffer_tb_top;
    import hog_cbuf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [CELL_W-1:0] wr_bins = '0;
    logic              wr_ready;
    logic              win_adv = 1'b0;
    logic              blk_valid;
    logic [BROW_W-1:0] blk_row;
    logic [BCOL_W-1:0] blk_col;
    logic [BLK_W-1:0]  blk_bins;

    int checks = 0;
    int fails  = 0;
    int g_next = 0;
    int nblk   = 0;
    int m_w = 0, m_r = 0, m_c = 0, m_idx = 0;
    int cyc = 0, last_cyc = 0;
    int gap_bad = 0;
    bit burst = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hog_cell_block_buffer dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_bins   (wr_bins),
        .wr_ready  (wr_ready),
        .win_adv   (win_adv),
        .blk_valid (blk_valid),
        .blk_row   (blk_row),
        .blk_col   (blk_col),
        .blk_bins  (blk_bins)
    );

    function automatic int bin_val(int g, int b);
        return ((g * 16 + b) * 7 + 3) % 4096;
    endfunction

    function automatic logic [CELL_W-1:0] cell_word(int g);
        logic [CELL_W-1:0] w;
        for (int b = 0; b < BINS; b++) w[b*BIN_W +: BIN_W] = BIN_W'(bin_val(g, b));
        return w;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Offer one cell (R2); returns at a negedge after acceptance
    task automatic put_cell();
        wr_valid = 1'b1;
        wr_bins  = cell_word(g_next);
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        g_next++;
    endtask

    task automatic pulse_adv();
        win_adv = 1'b1;
        @(negedge clk);
        win_adv = 1'b0;
    endtask

    // Block monitor: independent model of window, block order and contents
    always @(negedge clk) begin
        if (!rst && blk_valid) begin
            int bad_k, act_v, exp_v;
            bad_k = -1; act_v = 0; exp_v = 0;
            check(int'(blk_row) == m_r && int'(blk_col) == m_c, "R4", "block position",
                  int'(blk_row) * 16 + int'(blk_col), m_r * 16 + m_c);
            for (int k = 0; k < BLK_CELLS; k++) begin
                for (int b = 0; b < BINS; b++) begin
                    int g, a;
                    g = (m_w + m_r + k / 2) * CELLS_X + m_c + (k % 2);
                    a = int'(blk_bins[(k*BINS+b)*BIN_W +: BIN_W]);
                    if (bad_k < 0 && a != bin_val(g, b)) begin
                        bad_k = k * BINS + b; act_v = a; exp_v = bin_val(g, b);
                    end
                end
            end
            check(bad_k < 0, "R5", $sformatf("block bins (bin %0d)", bad_k), act_v, exp_v);
            if (burst && m_idx > 0 && cyc - last_cyc != BLK_CYCLES) gap_bad++;
            last_cyc = cyc;
            nblk++;
            m_idx++;
            if (m_c == BLK_X - 1) begin
                m_c = 0;
                if (m_r == BLK_Y - 1) begin
                    m_r = 0; m_w++; m_idx = 0;
                end else m_r++;
            end else m_c++;
        end
    end

    // Step table: advance first, cells to write, expected cumulative block count
    localparam int N_STEPS = 8;
    localparam int STEP_ADV  [N_STEPS] = '{0, 0, 0, 0, 0,   1,   0,   0};
    localparam int STEP_CELLS[N_STEPS] = '{9, 1, 6, 8, 104, 0,   5,   3};
    localparam int STEP_EXP  [N_STEPS] = '{0, 1, 7, 14, 105, 203, 207, 210};

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(blk_valid == 1'b0, "R1", "blk_valid after reset", int'(blk_valid), 0);
        check(wr_ready == 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);

        prev = 0;
        for (int s = 0; s < N_STEPS; s++) begin
            burst = (STEP_ADV[s] != 0);
            if (STEP_ADV[s] != 0) pulse_adv();
            for (int i = 0; i < STEP_CELLS[s]; i++) put_cell();
            repeat (9 * (STEP_EXP[s] - prev) + 40) @(negedge clk);
            // R3 availability, R8 advance re-emission
            check(nblk == STEP_EXP[s], STEP_ADV[s] != 0 ? "R8" : "R3",
                  $sformatf("block count after step %0d", s), nblk, STEP_EXP[s]);
            if (burst) check(gap_bad == 0, "R6", "gaps other than 8 in burst", gap_bad, 0);
            burst = 1'b0;
            prev = STEP_EXP[s];
        end

        // R7: window full, offered cell is held off and has no effect
        wr_valid = 1'b1;
        wr_bins  = cell_word(g_next);
        begin
            int low_cnt;
            low_cnt = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (wr_ready == 1'b0) low_cnt++;
            end
            check(low_cnt == 20, "R7", "cycles with wr_ready low while full", low_cnt, 20);
        end
        check(nblk == 210, "R7", "no blocks while stalled", nblk, 210);

        // R8: advance frees one row, held cell then accepted
        pulse_adv();
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        g_next++;

        // R9: advance during emission is remembered
        pulse_adv();
        for (int i = 0; i < 7; i++) put_cell();
        repeat (9 * 203 + 60) @(negedge clk);
        check(nblk == 413, "R9", "blocks after remembered advance", nblk, 413);
        check(wr_ready == 1'b1, "R8", "wr_ready after advance", int'(wr_ready), 1);

        // R1: reset clears the window
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wr_ready == 1'b1 && blk_valid == 1'b0, "R1", "state after second reset",
              int'(wr_ready) * 2 + int'(blk_valid), 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule